// File: doc/BRIEF.md
# MDIO Management Master

This block is a host-programmed master for the two-wire PHY management bus. It derives the management clock (MDC) from the system clock through a divider picked by a 3-bit code. It then shifts clause-22 read and write frames out to an external PHY. It also brings back the sixteen data bits of a read. The host sees a small register file through a single-cycle write port and a combinational read port.

A write frame begins when the host stores sixteen bits into the control register. A read frame begins when the read-cycle bit of the command register goes from 0 to 1. The PHY and register numbers come from the address register, and a busy flag tells the host when the wire is free again. A soft reset bit in the configuration register holds the frame engine idle for as long as it is set.

Register offsets on `wr_addr`/`rd_addr`: 0 configuration, 1 command, 2 address, 3 control, 4 indicator (read only), 5 status (read only).

Top module: `mdio_master`

## Requirements
- R1: Configuration bits [2:0] select the MDC period in system clocks. Code 1 gives 32, 2 gives 48, 3 gives 64, 4 gives 80, 5 gives 112, 6 gives 160 and 7 gives 224. Code 0 behaves as code 1.
- R2: MDC is low whenever no frame is in progress, and a frame spans exactly 64 MDC rising edges.
- R3: A host write to offset 3 starts a write frame, and bits [15:0] are the data. The 64 frame bits are sent MSB first. They are 32 ones, then 01, then opcode 01, then the 5-bit PHY address, the 5-bit register address, the turnaround 10 and the 16 data bits. MDIO output changes only when MDC falls, and the output enable is high for every bit.
- R4: A read frame carries the same header with opcode 10. The output enable is high for the first 46 bit periods and low for the last 18 bit periods, which are the turnaround and the data.
- R5: During a read, MDIO input is sampled on the MDC rising edges of the last 16 bit periods, MSB first. The result appears at status (offset 5) bits [15:0] once busy clears. With no PHY driving the pulled-up line, the result is 0xFFFF.
- R6: Indicator (offset 4) bit 0 reads 1 from the cycle after an accepted start request. It stays 1 until the last MDC falling edge of the frame, and MDC rises 64 times before it clears.
- R7: A control write that arrives while busy is 1 changes neither the stored control value nor the frame on the wire, and it starts no further frame.
- R8: Command (offset 1) bit 0 starts a read only on a 0-to-1 change written by the host. Writing 1 while it already holds 1 starts nothing.
- R9: Configuration bit 31 is a management reset. From the cycle after it is set, busy, MDC and the output enable are 0, and start requests are ignored until it is cleared.
- R10: The address register (offset 2) holds the PHY address in bits [12:8] and the register address in bits [4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Host write register offset |
| wr_data | input | 32 | Host write data |
| rd_addr | input | 3 | Host read register offset |
| rd_data | output | 32 | Host read data (combinational) |
| mdc | output | 1 | Management clock to PHY |
| mdio_i | input | 1 | MDIO pad input |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe | output | 1 | MDIO pad output enable |

## Verification
A host start request can land in a cycle where a frame is still shifting. The bench provokes this by writing a second control value about a hundred cycles into a write frame. It then judges the wire bits against the first value, reads the control register back, and confirms that busy stays low afterwards. A second case sets the soft reset bit in the middle of a frame, and a control write while the bit is held must leave busy, MDC and the enable low. Random frames with random codes, addresses, data and PHY presence check the divider period, the frame bits, the enable pattern and the captured word against bench functions.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int FRAME_BITS = PRE_BITS + 32;
  localparam int DRV_BITS   = PRE_BITS + 14;
  localparam int DATA_FIRST = PRE_BITS + 16;
  localparam int IW         = $clog2(FRAME_BITS);

  logic [2:0]            clk_sel;
  logic                  mgmt_rst;
  logic                  cmd_rd;
  logic [4:0]            phy_ad, reg_ad;
  logic [15:0]           ctrl_q, stat_q, rsh;
  logic                  busy, is_rd;
  logic [6:0]            cnt, half;
  logic [IW-1:0]         bit_idx;
  logic [FRAME_BITS-1:0] shreg;
  logic                  start_wr, start_rd;
  wire                   unused_bits = ^{wr_data[30:16]};

  always_comb begin
    case (clk_sel)
      3'd2:    half = 7'd24;
      3'd3:    half = 7'd32;
      3'd4:    half = 7'd40;
      3'd5:    half = 7'd56;
      3'd6:    half = 7'd80;
      3'd7:    half = 7'd112;
      default: half = 7'd16;
    endcase
  end

  assign start_wr = wr_en && wr_addr == 3'd3 && !busy && !mgmt_rst;
  assign start_rd = wr_en && wr_addr == 3'd1 && wr_data[0] && !cmd_rd && !busy && !mgmt_rst;
  assign mdio_o   = shreg[FRAME_BITS-1];

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = {mgmt_rst, 28'd0, clk_sel};
      3'd1:    rd_data = {31'd0, cmd_rd};
      3'd2:    rd_data = {19'd0, phy_ad, 3'd0, reg_ad};
      3'd3:    rd_data = {16'd0, ctrl_q};
      3'd4:    rd_data = {31'd0, busy};
      3'd5:    rd_data = {16'd0, stat_q};
      default: rd_data = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sel <= '0;
      mgmt_rst <= 1'b0;
      cmd_rd <= 1'b0;
      phy_ad <= '0;
      reg_ad <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: begin
          clk_sel  <= wr_data[2:0];
          mgmt_rst <= wr_data[31];
        end
        3'd1: cmd_rd <= wr_data[0];
        3'd2: begin
          phy_ad <= wr_data[12:8];
          reg_ad <= wr_data[4:0];
        end
        3'd3: if (start_wr) ctrl_q <= wr_data[15:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      is_rd <= 1'b0;
      mdc <= 1'b0;
      mdio_oe <= 1'b0;
      cnt <= '0;
      bit_idx <= '0;
      shreg <= '0;
      rsh <= '0;
      stat_q <= '0;
    end else if (mgmt_rst) begin
      busy <= 1'b0;
      mdc <= 1'b0;
      mdio_oe <= 1'b0;
      cnt <= '0;
      bit_idx <= '0;
    end else if (start_wr || start_rd) begin
      busy <= 1'b1;
      is_rd <= start_rd;
      mdc <= 1'b0;
      mdio_oe <= 1'b1;
      cnt <= '0;
      bit_idx <= '0;
      if (start_rd)
        shreg <= {{PRE_BITS{1'b1}}, 4'b0110, phy_ad, reg_ad, 18'h3FFFF};
      else
        shreg <= {{PRE_BITS{1'b1}}, 4'b0101, phy_ad, reg_ad, 2'b10, wr_data[15:0]};
    end else if (busy) begin
      if (cnt >= half - 7'd1) begin
        cnt <= '0;
        mdc <= ~mdc;
        if (!mdc) begin
          if (is_rd && bit_idx >= IW'(DATA_FIRST))
            rsh <= {rsh[14:0], mdio_i};
        end else if (bit_idx == IW'(FRAME_BITS - 1)) begin
          busy <= 1'b0;
          mdio_oe <= 1'b0;
          if (is_rd) stat_q <= rsh;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          shreg <= {shreg[FRAME_BITS-2:0], 1'b1};
          mdio_oe <= !(is_rd && bit_idx >= IW'(DRV_BITS - 1));
        end
      end else begin
        cnt <= cnt + 7'd1;
      end
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic       mdc,
  input logic       mdio_oe,
  input logic       busy,
  input logic       mgmt_rst,
  input logic       is_rd,
  input logic [5:0] bit_idx,
  input logic [15:0] ctrl_q
);
  // R2
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mdc);
  // R9
  soft_rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_rst |=> (!busy && !mdc && !mdio_oe));
  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd3 && !busy && !mgmt_rst) |=> busy);
  // R7
  ctrl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wr_addr == 3'd3) |=> $stable(ctrl_q));
  // R4
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_rd && bit_idx >= 6'd48) |-> !mdio_oe);
  // R3
  write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_rd) |-> mdio_oe);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .mdc(mdc),
  .mdio_oe(mdio_oe), .busy(busy), .mgmt_rst(mgmt_rst), .is_rd(is_rd),
  .bit_idx(bit_idx), .ctrl_q(ctrl_q)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        mdc, mdio_i = 1'b1, mdio_o, mdio_oe;

  int n_chk = 0, n_fail = 0;
  int bitn = 0;
  time t0 = 0, t1 = 0;
  logic [63:0] cap = '0, oecap = '0, resp = '1;

  mdio_master dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(posedge mdc);
    cap = {cap[62:0], mdio_o};
    oecap = {oecap[62:0], mdio_oe};
    if (bitn == 0) t0 = $time;
    if (bitn == 1) t1 = $time;
    bitn++;
  end

  initial forever begin
    @(negedge mdc);
    mdio_i = (bitn < 64) ? resp[63 - bitn] : 1'b1;
  end

  function automatic int exp_div(input logic [2:0] code);
    case (code)
      3'd2: return 48; 3'd3: return 64; 3'd4: return 80;
      3'd5: return 112; 3'd6: return 160; 3'd7: return 224;
      default: return 32;
    endcase
  endfunction

  function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, p, r, rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : d};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    host_rd(3'd4, v);
    while (v[0]) begin
      @(negedge clk);
      host_rd(3'd4, v);
    end
  endtask

  task automatic run_frame(input logic [2:0] code, input bit rd, input logic [4:0] p,
                           input logic [4:0] r, input logic [15:0] d, input bit present);
    logic [31:0] v;
    logic [63:0] ef;
    host_wr(3'd0, {29'd0, code});
    host_wr(3'd2, {19'd0, p, 3'd0, r});
    if (rd) host_wr(3'd1, 32'd0);
    resp = present ? {48'hFFFF_FFFF_FFFF, d} : 64'hFFFF_FFFF_FFFF_FFFF;
    bitn = 0;
    mdio_i = resp[63];
    if (rd) host_wr(3'd1, 32'd1); else host_wr(3'd3, {16'd0, d});
    host_rd(3'd4, v);
    chk("R6 busy after start", {63'd0, v[0]}, 64'd1);
    wait_idle();
    chk("R6 rising edges before idle", 64'(bitn), 64'd64);
    chk("R2 mdc idle low", {63'd0, mdc}, 64'd0);
    chk("R1 mdc period", 64'((t1 - t0) / CLK_PERIOD), 64'(exp_div(code)));
    ef = exp_frame(rd, p, r, d);
    if (rd) begin
      chk("R4 read header bits R10", {18'd0, cap[63:18]}, {18'd0, ef[63:18]});
      chk("R4 read enable pattern", oecap, {{46{1'b1}}, 18'd0});
      host_rd(3'd5, v);
      chk("R5 read data", {32'd0, v}, {48'd0, present ? d : 16'hFFFF});
      host_wr(3'd1, 32'd0);
    end else begin
      chk("R3 write frame bits R10", cap, ef);
      chk("R3 write enable all high", oecap, '1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    host_rd(3'd4, v); chk("R6 reset busy", {32'd0, v}, 64'd0);
    chk("R2 reset mdc", {62'd0, mdc, mdio_oe}, 64'd0);
    host_rd(3'd5, v); chk("R5 reset status", {32'd0, v}, 64'd0);

    run_frame(3'd1, 1'b0, 5'h1F, 5'h00, 16'hA5C3, 1'b1);
    run_frame(3'd7, 1'b0, 5'h00, 5'h1F, 16'h0001, 1'b1);
    run_frame(3'd6, 1'b1, 5'h15, 5'h0A, 16'h8001, 1'b1);
    run_frame(3'd0, 1'b1, 5'h03, 5'h01, 16'h1234, 1'b0);

    for (int i = 0; i < 10; i++)
      run_frame(3'($urandom % 5), 1'($urandom), 5'($urandom), 5'($urandom),
                16'($urandom), 1'($urandom));

    // R7: control write during a frame is dropped
    run_frame(3'd1, 1'b0, 5'h02, 5'h04, 16'hBEEF, 1'b1);
    bitn = 0;
    host_wr(3'd3, 32'h0000_1357);
    repeat (100) @(negedge clk);
    host_wr(3'd3, 32'h0000_2468);
    wait_idle();
    chk("R7 wire keeps first data", cap, exp_frame(1'b0, 5'h02, 5'h04, 16'h1357));
    host_rd(3'd3, v); chk("R7 control value kept", {32'd0, v}, 64'h1357);
    repeat (50) @(negedge clk);
    host_rd(3'd4, v); chk("R7 no second frame", {32'd0, v}, 64'd0);

    // R8: read needs a fresh 0-to-1
    host_wr(3'd0, 32'd1);
    resp = {48'hFFFF_FFFF_FFFF, 16'h00FF};
    bitn = 0; mdio_i = 1'b1;
    host_wr(3'd1, 32'd1);
    wait_idle();
    host_rd(3'd5, v); chk("R5 read via command bit", {32'd0, v}, 64'h00FF);
    host_wr(3'd1, 32'd1);
    host_rd(3'd4, v); chk("R8 repeated one ignored", {32'd0, v}, 64'd0);
    host_wr(3'd1, 32'd0);
    bitn = 0;
    host_wr(3'd1, 32'd1);
    host_rd(3'd4, v); chk("R8 fresh edge starts", {32'd0, v}, 64'd1);
    wait_idle();
    host_wr(3'd1, 32'd0);

    // R9: soft reset mid-frame
    host_wr(3'd3, 32'h0000_FFFF);
    repeat (300) @(negedge clk);
    host_wr(3'd0, 32'h8000_0001);
    @(negedge clk);
    host_rd(3'd4, v); chk("R9 busy cleared", {32'd0, v}, 64'd0);
    chk("R9 mdc and enable low", {62'd0, mdc, mdio_oe}, 64'd0);
    host_wr(3'd3, 32'h0000_0F0F);
    host_rd(3'd4, v); chk("R9 start ignored while held", {32'd0, v}, 64'd0);
    repeat (40) @(negedge clk);
    chk("R9 mdc stays low", {63'd0, mdc}, 64'd0);
    host_wr(3'd0, 32'h0000_0001);
    run_frame(3'd2, 1'b0, 5'h09, 5'h11, 16'h7E7E, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule